// File: doc/BRIEF.md
# Interrupt Destination Target Resolver

This block turns the addressing fields of an interrupt message into a set of receiving targets. A request carries a destination ID, a mode bit that picks physical or logical addressing, and a delivery mode. Each of N targets describes itself with a present flag, a physical ID, a logical ID and a priority value. The resolver compares the destination against every target in parallel and builds a match set.

In fixed delivery, the whole match set is returned. In lowest-priority delivery, the set is reduced to the one target that has the smallest priority value. Any other delivery mode is flagged as unsupported and returns no targets. An empty result means that no delivery takes place.

Results are registered. They appear one clock after the request strobe, together with a valid pulse and the unsupported flag.

Top module: `irq_dest_resolver`

## Requirements
- R1: While reset is asserted and after it is released, with no request made, valid_o, unsup_o and mask_o are all zero.
- R2: valid_o is high exactly in the cycle after a cycle in which req_i is high, and low otherwise. mask_o and unsup_o are zero whenever valid_o is low.
- R3: In physical mode (dest_logical_i = 0), destination 0xFF selects every present target.
- R4: In physical mode with any other destination, only the lowest-index present target whose physical ID equals the destination is selected. If no present target matches, the mask is zero.
- R5: In logical mode (dest_logical_i = 1), destination 0 selects no target.
- R6: In logical mode with a nonzero destination, every present target whose logical ID shares at least one set bit with the destination is selected.
- R7: With delivery mode code 0 (fixed), mask_o equals the full match set.
- R8: With delivery mode code 1 (lowest priority), mask_o has at most one bit set. That bit marks the matching target with the smallest priority value, with ties resolved to the lowest index. If the match set is empty, mask_o is zero.
- R9: With delivery mode codes 2 to 7, unsup_o is 1 and mask_o is zero. For codes 0 and 1, unsup_o is 0.
- R10: A target whose present flag is 0 is never selected, whatever its IDs or priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| dest_id_i | input | ID_W | Destination ID |
| dest_logical_i | input | 1 | 0 = physical addressing, 1 = logical addressing |
| dlv_mode_i | input | 3 | Delivery mode code (0 fixed, 1 lowest priority, other codes unsupported) |
| tgt_present_i | input | N_TGT | Present flag for each target |
| tgt_phys_id_i | input | N_TGT*ID_W | Physical ID of each target; target i occupies slice i |
| tgt_log_id_i | input | N_TGT*ID_W | Logical ID of each target; target i occupies slice i |
| tgt_prio_i | input | N_TGT*PRIO_W | Priority value of each target; a lower value wins |
| valid_o | output | 1 | Result valid pulse |
| unsup_o | output | 1 | The request used an unsupported delivery mode |
| mask_o | output | N_TGT | Selected targets |

## Verification
The target set is built with traps:
- Two targets share a physical ID, which separates first-match selection from all-match selection.
- An absent target carries the lowest priority value and IDs that would otherwise match, so it exposes any path that ignores the present flag.
- Two present targets tie on the minimum priority, which pins down the tie-break toward the lower index.

The same destinations are sent in both fixed and lowest-priority modes, so the reduction step can be told apart from the match step. Broadcast, no-match and zero-logical destinations, together with two unsupported mode codes, cover the empty-result paths.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [2:0] {
    DLV_FIXED  = 3'd0,
    DLV_LOWEST = 3'd1
  } dlv_mode_e;

  function automatic logic mode_supported(logic [2:0] m);
    return (m == DLV_FIXED) || (m == DLV_LOWEST);
  endfunction

endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
  parameter int N_TGT = 8,
  parameter int ID_W  = 8
) (
  input  logic [ID_W-1:0]       dest_id_i,
  input  logic                  dest_logical_i,
  input  logic [N_TGT-1:0]      present_i,
  input  logic [N_TGT*ID_W-1:0] phys_id_i,
  input  logic [N_TGT*ID_W-1:0] log_id_i,
  output logic [N_TGT-1:0]      match_o
);

  localparam logic [ID_W-1:0] BCAST_ID = {ID_W{1'b1}};

  logic [N_TGT-1:0] phys_eq;
  logic [N_TGT-1:0] log_hit;
  logic [N_TGT-1:0] phys_first;

  for (genvar g = 0; g < N_TGT; g++) begin : g_cmp
    assign phys_eq[g] = present_i[g] && (phys_id_i[g*ID_W +: ID_W] == dest_id_i);
    assign log_hit[g] = present_i[g] && |(log_id_i[g*ID_W +: ID_W] & dest_id_i);
  end

  // isolate lowest set bit: first matching target wins
  assign phys_first = phys_eq & (~phys_eq + N_TGT'(1));

  always_comb begin
    if (dest_logical_i)
      match_o = (dest_id_i == '0) ? '0 : log_hit;
    else if (dest_id_i == BCAST_ID)
      match_o = present_i;
    else
      match_o = phys_first;
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_TGT  = 8,
  parameter int PRIO_W = 4
) (
  input  logic [N_TGT-1:0]        cand_i,
  input  logic [N_TGT*PRIO_W-1:0] prio_i,
  output logic [N_TGT-1:0]        pick_o
);

  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1;

  logic              found;
  logic [PRIO_W-1:0] best_prio;
  logic [IDX_W-1:0]  best_idx;

  // strict less-than keeps the lower index on ties
  always_comb begin
    found     = 1'b0;
    best_prio = '0;
    best_idx  = '0;
    for (int i = 0; i < N_TGT; i++) begin
      if (cand_i[i] && (!found || (prio_i[i*PRIO_W +: PRIO_W] < best_prio))) begin
        found     = 1'b1;
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
        best_idx  = IDX_W'(i);
      end
    end
    pick_o = '0;
    pick_o[best_idx] = found;
  end

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_route_pkg::*;
#(
  parameter int N_TGT  = 8,
  parameter int ID_W   = 8,
  parameter int PRIO_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [ID_W-1:0]         dest_id_i,
  input  logic                    dest_logical_i,
  input  logic [2:0]              dlv_mode_i,
  input  logic [N_TGT-1:0]        tgt_present_i,
  input  logic [N_TGT*ID_W-1:0]   tgt_phys_id_i,
  input  logic [N_TGT*ID_W-1:0]   tgt_log_id_i,
  input  logic [N_TGT*PRIO_W-1:0] tgt_prio_i,
  output logic                    valid_o,
  output logic                    unsup_o,
  output logic [N_TGT-1:0]        mask_o
);

  logic [N_TGT-1:0] match;
  logic [N_TGT-1:0] pick;
  logic [N_TGT-1:0] sel;
  logic             supported;

  irq_dest_match #(.N_TGT(N_TGT), .ID_W(ID_W)) i_match (
    .dest_id_i      (dest_id_i),
    .dest_logical_i (dest_logical_i),
    .present_i      (tgt_present_i),
    .phys_id_i      (tgt_phys_id_i),
    .log_id_i       (tgt_log_id_i),
    .match_o        (match)
  );

  irq_prio_pick #(.N_TGT(N_TGT), .PRIO_W(PRIO_W)) i_pick (
    .cand_i (match),
    .prio_i (tgt_prio_i),
    .pick_o (pick)
  );

  assign supported = mode_supported(dlv_mode_i);

  always_comb begin
    unique case (dlv_mode_i)
      DLV_FIXED:  sel = match;
      DLV_LOWEST: sel = pick;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      unsup_o <= 1'b0;
      mask_o  <= '0;
    end else begin
      valid_o <= req_i;
      unsup_o <= req_i && !supported;
      mask_o  <= req_i ? sel : '0;
    end
  end

  p_valid_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !unsup_o && mask_o == '0));
  p_phys_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !dest_logical_i && dest_id_i != {ID_W{1'b1}}) |=> $onehot0(mask_o));
  p_logical_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && dest_logical_i && dest_id_i == '0) |=> (mask_o == '0));
  p_lowest_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && dlv_mode_i == DLV_LOWEST) |=> $onehot0(mask_o));
  p_unsup_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && dlv_mode_i > 3'd1) |=> (unsup_o && mask_o == '0));
  p_absent_never_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ((mask_o & ~$past(tgt_present_i)) == '0));

endmodule

// File: tb/test_irq_dest_resolver.sv
module test_irq_dest_resolver;

  localparam int N = 8;
  localparam int IW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [IW-1:0] dest = '0;
  logic          logical = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic [N-1:0]  present;
  logic [N*IW-1:0] phys_id;
  logic [N*IW-1:0] log_id;
  logic [N*PW-1:0] prio;
  logic          valid;
  logic          unsup;
  logic [N-1:0]  mask;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_dest_resolver #(.N_TGT(N), .ID_W(IW), .PRIO_W(PW)) i_irq_dest_resolver (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .dest_id_i(dest),
    .dest_logical_i(logical), .dlv_mode_i(mode), .tgt_present_i(present),
    .tgt_phys_id_i(phys_id), .tgt_log_id_i(log_id), .tgt_prio_i(prio),
    .valid_o(valid), .unsup_o(unsup), .mask_o(mask)
  );

  task automatic check(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, exp);
    end
  endtask

  // issue one request, sample result after the capturing edge
  task automatic run_req(input logic lg, input logic [IW-1:0] d, input logic [2:0] m);
    @(negedge clk);
    logical = lg; dest = d; mode = m; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_result(input string tag, input logic [N-1:0] exp_mask,
                               input logic exp_unsup);
    check(tag, "valid", 32'(valid), 32'd1);
    check(tag, "mask", 32'(mask), 32'(exp_mask));
    check(tag, "unsup", 32'(unsup), 32'(exp_unsup));
  endtask

  task automatic t_reset;
    check("R1", "valid in reset", 32'(valid), 32'd0);
    check("R1", "mask in reset", 32'(mask), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "valid idle", 32'(valid), 32'd0);
    check("R1", "unsup idle", 32'(unsup), 32'd0);
    check("R1", "mask idle", 32'(mask), 32'd0);
  endtask

  task automatic t_pulse;
    run_req(1'b0, 8'hFF, 3'd0);
    check("R2", "valid after req", 32'(valid), 32'd1);
    @(negedge clk);
    check("R2", "valid drops", 32'(valid), 32'd0);
    check("R2", "mask cleared", 32'(mask), 32'd0);
  endtask

  task automatic t_phys;
    run_req(1'b0, 8'hFF, 3'd0); expect_result("R3", 8'hBF, 1'b0);
    run_req(1'b0, 8'h12, 3'd0); expect_result("R4", 8'h04, 1'b0);
    run_req(1'b0, 8'h55, 3'd0); expect_result("R4", 8'h00, 1'b0);
    run_req(1'b0, 8'h16, 3'd0); expect_result("R10", 8'h00, 1'b0);
  endtask

  task automatic t_logical;
    run_req(1'b1, 8'h00, 3'd0); expect_result("R5", 8'h00, 1'b0);
    run_req(1'b1, 8'h04, 3'd0); expect_result("R6", 8'h0C, 1'b0);
    run_req(1'b1, 8'h14, 3'd0); expect_result("R7", 8'h3C, 1'b0);
  endtask

  task automatic t_lowest;
    run_req(1'b1, 8'h14, 3'd1); expect_result("R8", 8'h10, 1'b0);
    run_req(1'b1, 8'h0C, 3'd1); expect_result("R8", 8'h04, 1'b0);
    run_req(1'b0, 8'hFF, 3'd1); expect_result("R10", 8'h10, 1'b0);
    run_req(1'b1, 8'h00, 3'd1); expect_result("R8", 8'h00, 1'b0);
  endtask

  task automatic t_unsup;
    run_req(1'b0, 8'hFF, 3'd2); expect_result("R9", 8'h00, 1'b1);
    run_req(1'b1, 8'h14, 3'd7); expect_result("R9", 8'h00, 1'b1);
    @(negedge clk);
    check("R9", "unsup clears", 32'(unsup), 32'd0);
  endtask

  initial begin
    // target 6 absent with tempting IDs and the lowest priority
    present = 8'b1011_1111;
    phys_id = {8'h17, 8'h16, 8'h12, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
    log_id  = {8'h80, 8'h04, 8'h30, 8'h10, 8'h0C, 8'h04, 8'h02, 8'h01};
    prio    = {4'd9, 4'd0, 4'd1, 4'd1, 4'd7, 4'd3, 4'd3, 4'd5};
    @(negedge clk);
    t_reset();
    t_pulse();
    t_phys();
    t_logical();
    t_lowest();
    t_unsup();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule